// File: doc/BRIEF.md
# Branch Target and Next-PC Unit

This block works out where an 8-bit microcontroller core fetches next after a control-transfer instruction. The decode stage hands it the address of the current instruction, the instruction's byte length, its opcode byte and up to two operand bytes, a branch-kind code, and the state the branch condition depends on: accumulator, carry, one tested bit, the two compare operands, the loop counter, the data pointer and the return address just popped from the stack. One cycle later the block returns the next program counter, whether the branch was taken, and the side effects the core must apply: push a return address, write carry, clear the tested bit, write back the decremented counter.

Offsets are always counted from the first byte of the following instruction. Page-relative forms keep the upper five address bits of that following address and replace the lower eleven. All program-counter arithmetic wraps within a 64K space. Stack storage and instruction fetch stay outside the block.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output goes to zero at that edge.
- R2: A request presented with `req_valid` high at a rising edge gives its result at that edge with `res_valid` high; with `req_valid` low, `res_valid` is low after the edge and the strobes `taken`, `push_ret`, `carry_we` and `bit_clr` are all low.
- R3: The sequential address is `req_pc + req_len` modulo 65536. Kind 0 (none) and every branch whose condition fails return it as `next_pc` with `taken` low.
- R4: Kind 1 (short jump) and the taken conditional kinds 7 to 15 give the sequential address plus the sign-extended offset byte, modulo 65536. The offset byte is `req_b2` when `req_len` is 3 and `req_b1` otherwise.
- R5: Kinds 4 (long jump) and 5 (long call) give `{req_b1, req_b2}`, `req_b1` as the high byte.
- R6: Kinds 2 (page jump) and 3 (page call) give bits 15..11 of the sequential address, then bits 7..5 of `req_opc`, then `req_b1`.
- R7: Kinds 3 and 5 raise `push_ret` and `taken` and put the sequential address on `ret_addr`; no other kind raises `push_ret`.
- R8: Kind 6 (indexed) gives `dptr` plus the zero-extended accumulator, modulo 65536.
- R9: Kind 7 is taken when `acc` is zero, kind 8 when it is not; kind 9 is taken when `cy_in` is 1, kind 10 when it is 0.
- R10: Kind 11 is taken when `bit_in` is 1, kind 12 when it is 0; kind 13 is taken when `bit_in` is 1 and then also raises `bit_clr`, which stays low whenever kind 13 is not taken.
- R11: Kind 14 (compare) is taken when `cmp_lhs` differs from `cmp_rhs`, and always raises `carry_we` with `carry_out` set to 1 exactly when `cmp_lhs < cmp_rhs` unsigned; no other kind raises `carry_we`.
- R12: Kind 15 (decrement loop) puts `cnt_in - 1` modulo 256 on `cnt_out` and is taken exactly when that result is non-zero.
- R13: Kind 16 (return) is taken and gives `stack_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 5 | Branch-kind code (0 to 16) |
| req_pc | input | 16 | Address of the first byte of the current instruction |
| req_len | input | 2 | Instruction length in bytes (1 to 3) |
| req_opc | input | 8 | Opcode byte |
| req_b1 | input | 8 | Second instruction byte |
| req_b2 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator |
| cy_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Value of the addressed bit |
| cmp_lhs | input | 8 | First compare operand |
| cmp_rhs | input | 8 | Second compare operand |
| cnt_in | input | 8 | Loop counter before decrement |
| dptr | input | 16 | Data pointer |
| stack_pc | input | 16 | Return address popped from the stack |
| res_valid | output | 1 | Result present |
| next_pc | output | 16 | Address of the next instruction |
| taken | output | 1 | Control transfer taken |
| push_ret | output | 1 | Push `ret_addr` to the stack |
| ret_addr | output | 16 | Return address for calls |
| carry_we | output | 1 | Write `carry_out` to the carry flag |
| carry_out | output | 1 | New carry value |
| bit_clr | output | 1 | Clear the addressed bit |
| cnt_out | output | 8 | Decremented loop counter |

## Verification
The hardest cases to reach are those where the upper address bits do not come from where a naive design takes them. A page jump whose own address sits in the last two bytes of a 2K page must use the page of the following instruction. A relative branch near 0xFFFF must wrap to low memory. A three-byte conditional branch must take its offset from the third byte and not the second. The stimulus places instructions at 0x07FE and 0xFFFE and gives the second and third bytes different values, so a wrong pick yields a visibly different target. It also drives the decrement loop from counter values 1 and 0, the two values where the result falls on either side of zero.

// File: rtl/npc_pkg.sv
// Shared definitions for the next-PC unit: the branch-kind encoding.
// Assumes the decode stage produces these codes directly.
package npc_pkg;

    localparam int KIND_W = 5;

    typedef enum logic [KIND_W-1:0] {
        BK_NONE      = 5'd0,
        BK_SHORT     = 5'd1,
        BK_PAGE_JMP  = 5'd2,
        BK_PAGE_CALL = 5'd3,
        BK_LONG_JMP  = 5'd4,
        BK_LONG_CALL = 5'd5,
        BK_INDEXED   = 5'd6,
        BK_ACC_ZERO  = 5'd7,
        BK_ACC_NZ    = 5'd8,
        BK_CY_SET    = 5'd9,
        BK_CY_CLR    = 5'd10,
        BK_BIT_SET   = 5'd11,
        BK_BIT_CLR   = 5'd12,
        BK_BIT_TAKE  = 5'd13,
        BK_CMP_NE    = 5'd14,
        BK_DEC_NZ    = 5'd15,
        BK_RETURN    = 5'd16
    } br_kind_e;

endpackage

// File: rtl/npc_cond.sv
// Branch condition evaluator.
// Decides whether a kind transfers control and produces the side effects
// on carry, the tested bit and the loop counter. Purely combinational.
// Assumes: kind is a legal br_kind_e; unknown codes behave as BK_NONE.
module npc_cond
    import npc_pkg::*;
#(
    parameter int DW = 8
) (
    input  br_kind_e          kind,
    input  logic [DW-1:0]     acc,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [DW-1:0]     cmp_lhs,
    input  logic [DW-1:0]     cmp_rhs,
    input  logic [DW-1:0]     cnt_in,
    output logic              take,
    output logic              cy_we,
    output logic              cy_val,
    output logic              bclr,
    output logic [DW-1:0]     cnt_dec
);

    logic acc_is_zero;
    logic lhs_below;
    logic dec_nonzero;

    // Shared condition terms.
    always_comb begin
        acc_is_zero = (acc == '0);
        lhs_below   = (cmp_lhs < cmp_rhs);
        cnt_dec     = cnt_in - DW'(1);
        dec_nonzero = (cnt_dec != '0);
    end

    // Per-kind decision and side effects.
    always_comb begin
        take   = 1'b0;
        cy_we  = 1'b0;
        cy_val = 1'b0;
        bclr   = 1'b0;
        case (kind)
            BK_SHORT, BK_PAGE_JMP, BK_PAGE_CALL, BK_LONG_JMP,
            BK_LONG_CALL, BK_INDEXED, BK_RETURN: take = 1'b1;
            BK_ACC_ZERO: take = acc_is_zero;
            BK_ACC_NZ:   take = !acc_is_zero;
            BK_CY_SET:   take = cy_in;
            BK_CY_CLR:   take = !cy_in;
            BK_BIT_SET:  take = bit_in;
            BK_BIT_CLR:  take = !bit_in;
            BK_BIT_TAKE: begin
                take = bit_in;
                bclr = bit_in;
            end
            BK_CMP_NE: begin
                take   = (cmp_lhs != cmp_rhs);
                cy_we  = 1'b1;
                cy_val = lhs_below;
            end
            BK_DEC_NZ:   take = dec_nonzero;
            default:     take = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Branch destination generator.
// Forms the sequential address and the destination of every kind:
// relative, page-relative, long, indexed and return. Combinational.
// Assumes: len is 1..3; PAGE_W > DW; PC_W > PAGE_W.
module npc_target
    import npc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  br_kind_e          kind,
    input  logic [PC_W-1:0]   pc,
    input  logic [1:0]        len,
    input  logic [DW-1:0]     opc,
    input  logic [DW-1:0]     b1,
    input  logic [DW-1:0]     b2,
    input  logic [DW-1:0]     acc,
    input  logic [PC_W-1:0]   dptr,
    input  logic [PC_W-1:0]   stack_pc,
    output logic [PC_W-1:0]   seq,
    output logic [PC_W-1:0]   dest,
    output logic              is_call
);

    localparam int HI_W  = PAGE_W - DW;
    localparam int EXT_W = PC_W - DW;

    logic [DW-1:0]   rel_byte;
    logic [PC_W-1:0] rel_dest;
    logic [PC_W-1:0] page_dest;
    logic [PC_W-1:0] long_dest;
    logic [PC_W-1:0] idx_dest;

    // Sequential address and relative target from the following instruction.
    always_comb begin
        seq      = pc + PC_W'(len);
        rel_byte = (len == 2'd3) ? b2 : b1;
        rel_dest = seq + {{EXT_W{rel_byte[DW-1]}}, rel_byte};
        page_dest = {seq[PC_W-1:PAGE_W], opc[DW-1 -: HI_W], b1};
        idx_dest = dptr + PC_W'(acc);
    end

    // Long target layout depends on whether two bytes fill the PC exactly.
    generate
        if (PC_W == 2*DW) begin : g_long_exact
            assign long_dest = {b1, b2};
        end else begin : g_long_fit
            assign long_dest = PC_W'({b1, b2});
        end
    endgenerate

    // Destination select by kind.
    always_comb begin
        case (kind)
            BK_PAGE_JMP, BK_PAGE_CALL: dest = page_dest;
            BK_LONG_JMP, BK_LONG_CALL: dest = long_dest;
            BK_INDEXED:                dest = idx_dest;
            BK_RETURN:                 dest = stack_pc;
            BK_NONE:                   dest = seq;
            default:                   dest = rel_dest;
        endcase
        is_call = (kind == BK_PAGE_CALL) || (kind == BK_LONG_CALL);
    end

endmodule

// File: rtl/npc_unit.sv
// Next-PC unit top level.
// Registers one result per request, one cycle after the request edge.
// Combines the condition evaluator and destination generator.
// Assumes: the caller holds request fields stable for the request cycle.
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [1:0]        req_len,
    input  logic [DW-1:0]     req_opc,
    input  logic [DW-1:0]     req_b1,
    input  logic [DW-1:0]     req_b2,
    input  logic [DW-1:0]     acc,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [DW-1:0]     cmp_lhs,
    input  logic [DW-1:0]     cmp_rhs,
    input  logic [DW-1:0]     cnt_in,
    input  logic [PC_W-1:0]   dptr,
    input  logic [PC_W-1:0]   stack_pc,
    output logic              res_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              push_ret,
    output logic [PC_W-1:0]   ret_addr,
    output logic              carry_we,
    output logic              carry_out,
    output logic              bit_clr,
    output logic [DW-1:0]     cnt_out
);

    br_kind_e        kind;
    logic            c_take;
    logic            c_cy_we;
    logic            c_cy_val;
    logic            c_bclr;
    logic [DW-1:0]   c_cnt;
    logic [PC_W-1:0] t_seq;
    logic [PC_W-1:0] t_dest;
    logic            t_call;
    logic [PC_W-1:0] npc_c;

    // Map the raw kind code onto the enum.
    always_comb kind = br_kind_e'(req_kind);

    npc_cond #(.DW(DW)) u_cond (
        .kind    (kind),
        .acc     (acc),
        .cy_in   (cy_in),
        .bit_in  (bit_in),
        .cmp_lhs (cmp_lhs),
        .cmp_rhs (cmp_rhs),
        .cnt_in  (cnt_in),
        .take    (c_take),
        .cy_we   (c_cy_we),
        .cy_val  (c_cy_val),
        .bclr    (c_bclr),
        .cnt_dec (c_cnt)
    );

    npc_target #(.PC_W(PC_W), .DW(DW), .PAGE_W(PAGE_W)) u_tgt (
        .kind     (kind),
        .pc       (req_pc),
        .len      (req_len),
        .opc      (req_opc),
        .b1       (req_b1),
        .b2       (req_b2),
        .acc      (acc),
        .dptr     (dptr),
        .stack_pc (stack_pc),
        .seq      (t_seq),
        .dest     (t_dest),
        .is_call  (t_call)
    );

    // Pick destination or fall through.
    always_comb npc_c = c_take ? t_dest : t_seq;

    // Result register; strobes qualified by the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            push_ret  <= 1'b0;
            ret_addr  <= '0;
            carry_we  <= 1'b0;
            carry_out <= 1'b0;
            bit_clr   <= 1'b0;
            cnt_out   <= '0;
        end else begin
            res_valid <= req_valid;
            taken     <= req_valid && c_take;
            push_ret  <= req_valid && t_call;
            carry_we  <= req_valid && c_cy_we;
            bit_clr   <= req_valid && c_bclr;
            if (req_valid) begin
                next_pc   <= npc_c;
                ret_addr  <= t_seq;
                carry_out <= c_cy_val;
                cnt_out   <= c_cnt;
            end
        end
    end

    // R2: one result per request, one cycle later.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && !taken && !push_ret && !carry_we && !bit_clr);

    // R3: a result not taken falls through to the following instruction.
    a_r3_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !taken |-> next_pc == PC_W'($past(req_pc) + PC_W'($past(req_len))));

    // R6: page forms stay in the page of the following instruction.
    a_r6_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && ($past(req_kind) == KIND_W'(BK_PAGE_JMP) || $past(req_kind) == KIND_W'(BK_PAGE_CALL))
        |-> next_pc[PC_W-1:PAGE_W] == $past(req_pc + PC_W'(req_len)) >> PAGE_W);

    // R7: calls push the following address and always transfer.
    a_r7_call_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_ret |-> taken && ret_addr == PC_W'($past(req_pc) + PC_W'($past(req_len))));

    // R10: bit clear only on a taken test-and-clear.
    a_r10_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clr |-> taken && $past(req_kind) == KIND_W'(BK_BIT_TAKE) && $past(bit_in));

    // R11: carry written only by compare, from the unsigned order.
    a_r11_carry: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |-> $past(req_kind) == KIND_W'(BK_CMP_NE) && carry_out == ($past(cmp_lhs) < $past(cmp_rhs)));

    // R12: decrement loop taken exactly on a non-zero result.
    a_r12_loop: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(req_kind) == KIND_W'(BK_DEC_NZ) |-> taken == (cnt_out != '0));

endmodule

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
    import npc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_kind = '0;
    logic [15:0] req_pc = '0;
    logic [1:0]  req_len = 2'd1;
    logic [7:0]  req_opc = '0, req_b1 = '0, req_b2 = '0;
    logic [7:0]  acc = '0, cmp_lhs = '0, cmp_rhs = '0, cnt_in = '0;
    logic        cy_in = 1'b0, bit_in = 1'b0;
    logic [15:0] dptr = '0, stack_pc = '0;
    logic        res_valid, taken, push_ret, carry_we, carry_out, bit_clr;
    logic [15:0] next_pc, ret_addr;
    logic [7:0]  cnt_out;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] npc;
        logic        tk;
        logic        push;
        logic [15:0] ret;
        logic        cwe;
        logic        cval;
        logic        bclr;
        logic [7:0]  cnt;
        br_kind_e    k;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_pc(req_pc), .req_len(req_len), .req_opc(req_opc), .req_b1(req_b1),
        .req_b2(req_b2), .acc(acc), .cy_in(cy_in), .bit_in(bit_in),
        .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs), .cnt_in(cnt_in), .dptr(dptr),
        .stack_pc(stack_pc), .res_valid(res_valid), .next_pc(next_pc),
        .taken(taken), .push_ret(push_ret), .ret_addr(ret_addr),
        .carry_we(carry_we), .carry_out(carry_out), .bit_clr(bit_clr),
        .cnt_out(cnt_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: present one request on the falling edge and queue its expectation.
    task automatic issue(input br_kind_e k, input logic [15:0] pc, input logic [1:0] len,
                         input logic [7:0] opc, input logic [7:0] b1, input logic [7:0] b2,
                         input string req);
        exp_t e;
        logic [15:0] nxt, dst;
        logic [7:0]  off, dec;
        logic        go;
        nxt = pc + {14'd0, len};
        off = (len == 2'd3) ? b2 : b1;
        dec = cnt_in - 8'd1;
        go  = 1'b1;
        dst = nxt + {{8{off[7]}}, off};
        case (k)
            BK_NONE:      go = 1'b0;
            BK_PAGE_JMP, BK_PAGE_CALL: dst = {nxt[15:11], opc[7:5], b1};
            BK_LONG_JMP, BK_LONG_CALL: dst = {b1, b2};
            BK_INDEXED:   dst = dptr + {8'd0, acc};
            BK_RETURN:    dst = stack_pc;
            BK_ACC_ZERO:  go = (acc == 8'd0);
            BK_ACC_NZ:    go = (acc != 8'd0);
            BK_CY_SET:    go = cy_in;
            BK_CY_CLR:    go = !cy_in;
            BK_BIT_SET, BK_BIT_TAKE: go = bit_in;
            BK_BIT_CLR:   go = !bit_in;
            BK_CMP_NE:    go = (cmp_lhs != cmp_rhs);
            BK_DEC_NZ:    go = (dec != 8'd0);
            default:      ;
        endcase
        e.npc  = go ? dst : nxt;
        e.tk   = go;
        e.push = (k == BK_PAGE_CALL || k == BK_LONG_CALL);
        e.ret  = nxt;
        e.cwe  = (k == BK_CMP_NE);
        e.cval = (cmp_lhs < cmp_rhs);
        e.bclr = (k == BK_BIT_TAKE) && bit_in;
        e.cnt  = dec;
        e.k    = k;
        e.req  = req;
        req_valid = 1'b1;
        req_kind  = k;
        req_pc    = pc;
        req_len   = len;
        req_opc   = opc;
        req_b1    = b1;
        req_b2    = b2;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each result against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                chk("R2", "unexpected result", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, "next_pc", next_pc, e.npc);
                chk(e.req, "taken", {15'd0, taken}, {15'd0, e.tk});
                chk("R7", "push_ret", {15'd0, push_ret}, {15'd0, e.push});
                if (e.push) chk("R7", "ret_addr", ret_addr, e.ret);
                chk("R11", "carry_we", {15'd0, carry_we}, {15'd0, e.cwe});
                if (e.cwe) chk("R11", "carry_out", {15'd0, carry_out}, {15'd0, e.cval});
                chk("R10", "bit_clr", {15'd0, bit_clr}, {15'd0, e.bclr});
                if (e.k == BK_DEC_NZ) chk("R12", "cnt_out", {8'd0, cnt_out}, {8'd0, e.cnt});
            end
        end
    end

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk("R1", "res_valid", {15'd0, res_valid}, 16'd0);
        chk("R1", "next_pc", next_pc, 16'd0);
        chk("R1", "strobes", {12'd0, taken, push_ret, carry_we, bit_clr}, 16'd0);
        chk("R1", "cnt_out", {8'd0, cnt_out}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: fall through, including wrap.
        issue(BK_NONE, 16'h1234, 2'd1, 8'h00, 8'h00, 8'h00, "R3");
        issue(BK_NONE, 16'hFFFF, 2'd3, 8'h00, 8'h77, 8'h88, "R3");
        // R4: short relative forward, backward, wrap past 0xFFFF.
        issue(BK_SHORT, 16'h0100, 2'd2, 8'h80, 8'h10, 8'h00, "R4");
        issue(BK_SHORT, 16'h0100, 2'd2, 8'h80, 8'hFE, 8'h00, "R4");
        issue(BK_SHORT, 16'hFFFE, 2'd2, 8'h80, 8'h05, 8'h00, "R4");
        // R5: long forms; R7: call pushes following address.
        issue(BK_LONG_JMP, 16'h4000, 2'd3, 8'h02, 8'h12, 8'h34, "R5");
        issue(BK_LONG_CALL, 16'h2000, 2'd3, 8'h12, 8'hAB, 8'hCD, "R7");
        // R6: page forms, one crossing into the next page.
        issue(BK_PAGE_JMP, 16'h07FE, 2'd2, 8'hE1, 8'h55, 8'h00, "R6");
        issue(BK_PAGE_JMP, 16'h1234, 2'd2, 8'h41, 8'h00, 8'h00, "R6");
        issue(BK_PAGE_CALL, 16'h3000, 2'd2, 8'h31, 8'h80, 8'h00, "R7");
        // R8: indexed with wrap.
        acc = 8'h80; dptr = 16'hFFF0;
        issue(BK_INDEXED, 16'h0500, 2'd1, 8'h73, 8'h00, 8'h00, "R8");
        // R9: accumulator and carry conditions.
        acc = 8'h00;
        issue(BK_ACC_ZERO, 16'h0200, 2'd2, 8'h60, 8'h20, 8'h00, "R9");
        acc = 8'h05;
        issue(BK_ACC_ZERO, 16'h0200, 2'd2, 8'h60, 8'h20, 8'h00, "R9");
        issue(BK_ACC_NZ, 16'h0200, 2'd2, 8'h70, 8'h80, 8'h00, "R9");
        cy_in = 1'b1;
        issue(BK_CY_SET, 16'h0300, 2'd2, 8'h40, 8'h08, 8'h00, "R9");
        issue(BK_CY_CLR, 16'h0300, 2'd2, 8'h50, 8'h08, 8'h00, "R9");
        cy_in = 1'b0;
        issue(BK_CY_CLR, 16'h0300, 2'd2, 8'h50, 8'hF0, 8'h00, "R9");
        // R10: bit tests; offset from third byte; clear only when taken.
        bit_in = 1'b1;
        issue(BK_BIT_SET, 16'h0400, 2'd3, 8'h20, 8'h21, 8'h04, "R10");
        issue(BK_BIT_CLR, 16'h0400, 2'd3, 8'h30, 8'h21, 8'h04, "R10");
        issue(BK_BIT_TAKE, 16'h0400, 2'd3, 8'h10, 8'h21, 8'hFC, "R10");
        bit_in = 1'b0;
        issue(BK_BIT_TAKE, 16'h0400, 2'd3, 8'h10, 8'h21, 8'hFC, "R10");
        // R11: compare less, equal, greater.
        cmp_lhs = 8'h03; cmp_rhs = 8'h07;
        issue(BK_CMP_NE, 16'h0600, 2'd3, 8'hB4, 8'h07, 8'h10, "R11");
        cmp_lhs = 8'h07;
        issue(BK_CMP_NE, 16'h0600, 2'd3, 8'hB4, 8'h07, 8'h10, "R11");
        cmp_lhs = 8'h09; cmp_rhs = 8'h02;
        issue(BK_CMP_NE, 16'h0600, 2'd3, 8'hB4, 8'h02, 8'hF0, "R11");
        // R12: decrement around zero.
        cnt_in = 8'h01;
        issue(BK_DEC_NZ, 16'h0700, 2'd2, 8'hD8, 8'hFB, 8'h00, "R12");
        cnt_in = 8'h00;
        issue(BK_DEC_NZ, 16'h0700, 2'd2, 8'hD8, 8'hFB, 8'h00, "R12");
        cnt_in = 8'h05;
        issue(BK_DEC_NZ, 16'h0700, 2'd3, 8'hD5, 8'h40, 8'hFD, "R12");
        // R13: return.
        stack_pc = 16'hBEEF;
        issue(BK_RETURN, 16'h0800, 2'd1, 8'h22, 8'h00, 8'h00, "R13");

        // R2: idle cycles produce no result.
        @(negedge clk);
        chk("R2", "idle res_valid", {15'd0, res_valid}, 16'd0);
        chk("R2", "idle strobes", {12'd0, taken, push_ret, carry_we, bit_clr}, 16'd0);
        repeat (3) @(negedge clk);
        chk("R2", "queue drained", 16'(sb.size()), 16'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule